// File: doc/BRIEF.md
# Dual Parallel Port Register Block

This block holds the host-visible registers behind two 8-bit bidirectional parallel ports, A and B. Each port has a data register, which holds the value to drive, and a direction register, where a bit of 1 makes the matching pin an output and a bit of 0 makes it an input. The host reaches the four registers through a 4-bit register select, a chip select, a write strobe and an 8-bit data bus. Writes are taken on the rising clock edge. Reads are combinational.

Port A acts as an open-drain port. For each pin the block raises a pull-low request only when that pin is an output and its data bit is 0. Port B acts as a push-pull port. Each pin gets a separate enable and value toward its pad, and the value for bit 7 leaves the block inverted. Reading either data address returns the live pin levels, not the stored data. Reading a direction address returns the stored direction bits.

Top module: `pport_regs`

## Requirements
- R1: When rst_n is sampled low at a rising clock edge, all four registers become zero after that edge. Then pa_pull_low = 8'h00, pb_oe = 8'h00, pb_out = 8'h80, and both direction addresses read 8'h00.
- R2: A write happens at a rising edge where cs = 1 and wr = 1. It loads wdata into the register chosen by addr and leaves the others unchanged. The addresses are: 0 = port B data, 1 = port A data, 2 = port B direction, 3 = port A direction.
- R3: Bit i of pa_pull_low is 1 exactly when port A direction bit i is 1 and port A data bit i is 0.
- R4: pb_oe equals the port B direction register, bit for bit.
- R5: pb_out[6:0] equals port B data bits 6..0, and pb_out[7] is the inverse of port B data bit 7.
- R6: With cs = 1 and wr = 0, address 1 reads pa_pin and address 0 reads pb_pin, with no clock needed. This holds whatever the direction and data bits are.
- R7: With cs = 1 and wr = 0, address 2 reads the port B direction register and address 3 reads the port A direction register.
- R8: Addresses 4 to 15 read 8'h00, and writes to them change no register and no output.
- R9: At an edge where cs = 0 or wr = 0, no register changes, even if the other strobe is high.
- R10: rdata is 8'h00 whenever cs = 0 or wr = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; writes and reset are taken on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cs | input | 1 | Chip select |
| wr | input | 1 | Write strobe (1 = write, 0 = read) |
| addr | input | 4 | Register select |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational |
| pa_pin | input | 8 | Live port A pin levels |
| pb_pin | input | 8 | Live port B pin levels |
| pa_pull_low | output | 8 | Per pin, 1 = pull the port A pin to ground |
| pb_oe | output | 8 | Per pin port B output enable |
| pb_out | output | 8 | Port B pin values; bit 7 inverted |

## Verification
The bench holds a port A pin high from outside while the block is told to drive that pin high. A design that returned the stored data instead of the pin level would read back the register value and miss external changes. Bit 7 of port B is checked with both data values, so a missing inversion, or an inversion on every bit, shows up on pb_out right after reset and after each write. Writes to unmapped addresses, and writes with only one of the two strobes high, are checked at the outputs and through direction readback. A design that decoded addr too loosely, or took a write on a single strobe, would change pb_oe, pb_out or pa_pull_low.

// File: rtl/pport_pkg.sv
// Package: shared widths and register-select codes for the parallel port block.
// Assumes a 4-bit register select with four mapped codes.
package pport_pkg;
    localparam int PORT_W = 8;
    localparam int ADDR_W = 4;

    localparam logic [ADDR_W-1:0] SEL_B_DATA = 4'd0;
    localparam logic [ADDR_W-1:0] SEL_A_DATA = 4'd1;
    localparam logic [ADDR_W-1:0] SEL_B_DIR  = 4'd2;
    localparam logic [ADDR_W-1:0] SEL_A_DIR  = 4'd3;
endpackage

// File: rtl/pport_reg.sv
// Module: one host-writable static register bit array.
// Assumes the write enable is already decoded; reset is synchronous, active low.
module pport_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    // Hold the value; clear on reset, load on write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= '0;
        else if (we)
            q <= d;
    end
endmodule

// File: rtl/pport_drv_a.sv
// Module: open-drain pad control for port A.
// A pin is pulled low only if it is an output with data 0; otherwise it is released.
module pport_drv_a #(
    parameter int W = 8
) (
    input  logic [W-1:0] data,
    input  logic [W-1:0] dir,
    output logic [W-1:0] pull_low
);
    genvar i;
    generate
        for (i = 0; i < W; i++) begin : g_bit
            // Per-pin pull-low request.
            assign pull_low[i] = dir[i] & ~data[i];
        end
    endgenerate
endmodule

// File: rtl/pport_drv_b.sv
// Module: push-pull pad control for port B, with separate enable and value per pin.
// When INV_MSB is set, the top bit's value leaves the block inverted.
module pport_drv_b #(
    parameter int W       = 8,
    parameter bit INV_MSB = 1'b1
) (
    input  logic [W-1:0] data,
    input  logic [W-1:0] dir,
    output logic [W-1:0] oe,
    output logic [W-1:0] value
);
    assign oe = dir;

    genvar i;
    generate
        for (i = 0; i < W; i++) begin : g_bit
            if (INV_MSB && (i == W - 1)) begin : g_inv
                // Top bit: active-low value.
                assign value[i] = ~data[i];
            end else begin : g_pass
                // Lower bits: value taken straight from the register.
                assign value[i] = data[i];
            end
        end
    endgenerate
endmodule

// File: rtl/pport_regs.sv
// Module: top of the dual parallel port register block.
// Decodes host writes into four registers, drives the pad controls, and
// muxes live pin levels or direction bits onto the combinational read bus.
// Assumes the host holds addr, wdata and the strobes stable around the clock edge.
module pport_regs
    import pport_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [PORT_W-1:0] wdata,
    output logic [PORT_W-1:0] rdata,
    input  logic [PORT_W-1:0] pa_pin,
    input  logic [PORT_W-1:0] pb_pin,
    output logic [PORT_W-1:0] pa_pull_low,
    output logic [PORT_W-1:0] pb_oe,
    output logic [PORT_W-1:0] pb_out
);
    localparam int NREG = 4;

    logic [NREG-1:0]   we_vec;
    logic [PORT_W-1:0] reg_q [NREG];
    logic              wr_go;
    logic              rd_go;

    assign wr_go = cs & wr;
    assign rd_go = cs & ~wr;

    // Decode the write strobe into one enable per register.
    always_comb begin
        we_vec = '0;
        if (wr_go && (addr < ADDR_W'(NREG)))
            we_vec[addr[1:0]] = 1'b1;
    end

    genvar r;
    generate
        for (r = 0; r < NREG; r++) begin : g_reg
            pport_reg #(.W(PORT_W)) u_reg (
                .clk   (clk),
                .rst_n (rst_n),
                .we    (we_vec[r]),
                .d     (wdata),
                .q     (reg_q[r])
            );
        end
    endgenerate

    pport_drv_a #(.W(PORT_W)) u_drv_a (
        .data     (reg_q[SEL_A_DATA[1:0]]),
        .dir      (reg_q[SEL_A_DIR[1:0]]),
        .pull_low (pa_pull_low)
    );

    pport_drv_b #(.W(PORT_W), .INV_MSB(1'b1)) u_drv_b (
        .data  (reg_q[SEL_B_DATA[1:0]]),
        .dir   (reg_q[SEL_B_DIR[1:0]]),
        .oe    (pb_oe),
        .value (pb_out)
    );

    // Read mux: live pins for data addresses, stored bits for direction addresses.
    always_comb begin
        rdata = '0;
        if (rd_go) begin
            case (addr)
                SEL_B_DATA: rdata = pb_pin;
                SEL_A_DATA: rdata = pa_pin;
                SEL_B_DIR:  rdata = reg_q[SEL_B_DIR[1:0]];
                SEL_A_DIR:  rdata = reg_q[SEL_A_DIR[1:0]];
                default:    rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/pport_regs_chk.sv
// Module: property checker for pport_regs, attached with bind.
// Watches the ports only.
module pport_regs_chk
    import pport_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              cs,
    input logic              wr,
    input logic [ADDR_W-1:0] addr,
    input logic [PORT_W-1:0] wdata,
    input logic [PORT_W-1:0] rdata,
    input logic [PORT_W-1:0] pa_pin,
    input logic [PORT_W-1:0] pb_pin,
    input logic [PORT_W-1:0] pa_pull_low,
    input logic [PORT_W-1:0] pb_oe,
    input logic [PORT_W-1:0] pb_out
);
    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (pa_pull_low == '0) && (pb_oe == '0) && (pb_out == 8'h80));

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(cs && wr) |=> $stable(pa_pull_low) && $stable(pb_oe) && $stable(pb_out));

    // R8
    unmapped_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cs && wr && addr > 4'd3) |=> $stable(pa_pull_low) && $stable(pb_oe) && $stable(pb_out));

    // R4
    b_dir_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cs && wr && addr == 4'd2) |=> pb_oe == $past(wdata));

    // R5
    b_data_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cs && wr && addr == 4'd0) |=> pb_out == ($past(wdata) ^ 8'h80));

    // R3
    a_dir_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cs && wr && addr == 4'd3) |=> (pa_pull_low & ~$past(wdata)) == '0);

    // R6
    a_live_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cs && !wr && addr == 4'd1) |-> rdata == pa_pin);

    // R10
    quiet_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs || wr) |-> rdata == '0);
endmodule

bind pport_regs pport_regs_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cs          (cs),
    .wr          (wr),
    .addr        (addr),
    .wdata       (wdata),
    .rdata       (rdata),
    .pa_pin      (pa_pin),
    .pb_pin      (pb_pin),
    .pa_pull_low (pa_pull_low),
    .pb_oe       (pb_oe),
    .pb_out      (pb_out)
);

// File: tb/pport_regs_tb.sv
// Bench: a table-driven write sequence, then directed tests for reads and corner cases.
module pport_regs_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs = 1'b0;
    logic       wr = 1'b0;
    logic [3:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic [7:0] pa_pin = '0;
    logic [7:0] pb_pin = '0;
    logic [7:0] pa_pull_low;
    logic [7:0] pb_oe;
    logic [7:0] pb_out;

    int n_checks = 0;
    int n_fail   = 0;

    always #2 clk = ~clk;

    pport_regs u_dut (
        .clk (clk), .rst_n (rst_n), .cs (cs), .wr (wr), .addr (addr),
        .wdata (wdata), .rdata (rdata), .pa_pin (pa_pin), .pb_pin (pb_pin),
        .pa_pull_low (pa_pull_low), .pb_oe (pb_oe), .pb_out (pb_out)
    );

    // Vector: {addr, wdata, expected pa_pull_low, expected pb_oe, expected pb_out}
    localparam int NV = 9;
    localparam logic [35:0] VEC [NV] = '{
        {4'd3, 8'hF0, 8'hF0, 8'h00, 8'h80},
        {4'd1, 8'h30, 8'hC0, 8'h00, 8'h80},
        {4'd2, 8'h0F, 8'hC0, 8'h0F, 8'h80},
        {4'd0, 8'h85, 8'hC0, 8'h0F, 8'h05},
        {4'd0, 8'h7A, 8'hC0, 8'h0F, 8'hFA},
        {4'd5, 8'hFF, 8'hC0, 8'h0F, 8'hFA},
        {4'd3, 8'h00, 8'h00, 8'h0F, 8'hFA},
        {4'd1, 8'h00, 8'h00, 8'h0F, 8'hFA},
        {4'd3, 8'h81, 8'h81, 8'h0F, 8'hFA}
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One clocked write; returns at the following falling edge.
    task automatic do_write(input logic [3:0] a, input logic [7:0] d,
                            input logic c, input logic w);
        cs = c; wr = w; addr = a; wdata = d;
        @(posedge clk);
        @(negedge clk);
        cs = 1'b0; wr = 1'b0;
    endtask

    task automatic read_at(input logic [3:0] a, output logic [7:0] v);
        cs = 1'b1; wr = 1'b0; addr = a;
        #1;
        v = rdata;
        cs = 1'b0;
        #1;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        #(4 * 200000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [7:0] v;
        @(negedge clk);
        @(negedge clk);
        // R1: reset state, no pin driven
        check("R1 pa_pull_low", pa_pull_low, 8'h00);
        check("R1 pb_oe", pb_oe, 8'h00);
        check("R1 pb_out", pb_out, 8'h80);
        rst_n = 1'b1;
        @(negedge clk);
        read_at(4'd2, v); check("R1 B dir read", v, 8'h00);
        read_at(4'd3, v); check("R1 A dir read", v, 8'h00);

        // R2 R3 R4 R5 R8: write table
        for (int k = 0; k < NV; k++) begin
            do_write(VEC[k][35:32], VEC[k][31:24], 1'b1, 1'b1);
            check("R3 pa_pull_low", pa_pull_low, VEC[k][23:16]);
            check("R4 pb_oe", pb_oe, VEC[k][15:8]);
            check("R5 pb_out", pb_out, VEC[k][7:0]);
        end

        // R7: direction readback
        read_at(4'd2, v); check("R7 B dir", v, 8'h0F);
        read_at(4'd3, v); check("R7 A dir", v, 8'h81);

        // R6: live pin reads; A bit 0 is an output with data 1 set below, pin held high
        do_write(4'd1, 8'h01, 1'b1, 1'b1);
        check("R3 released pin", pa_pull_low, 8'h80);
        pa_pin = 8'hA5; pb_pin = 8'h3C;
        read_at(4'd1, v); check("R6 A pins", v, 8'hA5);
        read_at(4'd0, v); check("R6 B pins", v, 8'h3C);
        pa_pin = 8'h5B;
        read_at(4'd1, v); check("R6 A pins change", v, 8'h5B);

        // R8: unmapped read and write
        read_at(4'd9, v); check("R8 unmapped read", v, 8'h00);
        do_write(4'd15, 8'hFF, 1'b1, 1'b1);
        read_at(4'd2, v); check("R8 B dir kept", v, 8'h0F);
        read_at(4'd3, v); check("R8 A dir kept", v, 8'h81);

        // R9: single strobes ignored
        do_write(4'd2, 8'hAA, 1'b0, 1'b1);
        check("R9 cs low", pb_oe, 8'h0F);
        do_write(4'd2, 8'hAA, 1'b1, 1'b0);
        check("R9 wr low", pb_oe, 8'h0F);
        read_at(4'd3, v); check("R9 A dir held", v, 8'h81);

        // R10: quiet bus
        cs = 1'b0; wr = 1'b0; addr = 4'd1; #1;
        check("R10 cs low", rdata, 8'h00);
        cs = 1'b1; wr = 1'b1; addr = 4'd1; #1;
        check("R10 wr high", rdata, 8'h00);
        cs = 1'b0; wr = 1'b0;
        @(negedge clk);

        // R5: bit 7 set in B data
        do_write(4'd0, 8'h80, 1'b1, 1'b1);
        check("R5 msb inverted", pb_out, 8'h00);

        // R1: reset mid-run
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check("R1 rerun pa_pull_low", pa_pull_low, 8'h00);
        check("R1 rerun pb_oe", pb_oe, 8'h00);
        check("R1 rerun pb_out", pb_out, 8'h80);
        rst_n = 1'b1;
        @(negedge clk);
        read_at(4'd3, v); check("R1 rerun A dir", v, 8'h00);

        finish_run();
    end
endmodule